// File: doc/BRIEF.md
# Thread-Partitioned Return Address Stack

This block predicts return targets for a core that runs up to four hardware threads. A single pool of 16 return-address entries is carved into equal slices, one per running thread. How large a slice is depends only on how many threads are active: a lone thread gets the whole pool, a pair gets half each, and three or four threads get a quarter each. There is no three-way split, so with three threads one quarter of the pool sits idle.

A call pushes its return address into the calling thread's slice. A return pops the newest entry of that slice, and the prediction comes out, with a valid flag, one cycle after the pop request. Each slice is a circular buffer: once full, a new push overwrites the oldest entry, and a pop from an empty slice yields an invalid prediction. Whenever the number of active threads changes, every slice is emptied, because the slice boundaries move.

A thread's slice is chosen by its rank among the active threads: the number of active threads with a lower ID. The slice starts at rank × slice size. Requests from threads that are not marked active are dropped.

Top module: `ret_stack_part`

## Requirements
- R1: While reset is held, and after it until the first accepted push, `pred_vld` is 0 and every pop returns an invalid prediction.
- R2: Slice capacity is 16 entries with one active thread (an all-zero mask counts as one), 8 with two, and 4 with three or four.
- R3: A pop accepted at a rising clock edge drives `pred_vld`/`pred_addr` from that edge until the next one. The result is the newest address pushed by the same thread that has not already been popped. In any cycle without an accepted pop, `pred_vld` is 0.
- R4: A push into a full slice discards the oldest entry. After N pushes into a slice of capacity C with N > C, pops return the last C addresses, newest first, and after that they are invalid.
- R5: A pop from an empty slice gives `pred_vld` = 0 and `pred_addr` = 0 in the following cycle. The slice stays empty.
- R6: The slice of an active thread starts at physical entry rank × capacity, where rank is the number of active threads with a lower ID. Pushes and pops of one thread never change what another thread pops.
- R7: With exactly three threads active, each of them holds 4 entries and the fourth quarter of the pool is unused.
- R8: In a cycle whose active-thread count differs from that of the previous cycle (the count is 0 during reset), all slices are emptied and that cycle's push and pop are discarded.
- R9: A push and a pop for the same thread in the same cycle act as a pop followed by a push. The prediction is the old newest entry, and the pushed address becomes the new newest entry. On an empty slice the pop is invalid and the push is kept.
- R10: Push and pop requests whose thread ID is not set in `act_mask` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_mask | input | 4 | One bit per hardware thread, 1 = thread running |
| push_vld | input | 1 | Call: push `push_addr` for `push_tid` |
| push_tid | input | 2 | Thread issuing the push |
| push_addr | input | 32 | Return address to store |
| pop_vld | input | 1 | Return: pop a prediction for `pop_tid` |
| pop_tid | input | 2 | Thread issuing the pop |
| pred_vld | output | 1 | Prediction valid, one cycle after an accepted pop |
| pred_addr | output | 32 | Predicted return target, 0 when not valid |

## Verification
The prediction is the only registered result. It is due in the cycle after the edge that accepts the pop. Slice contents change at that same edge, so a pop in the next cycle already sees them. A change in the active-thread count takes effect in the cycle in which the new mask is presented. The bench changes inputs on the falling edge and reads `pred_vld`/`pred_addr` on the next falling edge, which is exactly one register stage after the requesting edge. Its per-thread model empties itself on the step in which the mask's population count changes.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  // log2 of the number of slices the pool is cut into for nact threads
  function automatic int unsigned slice_log2(input int unsigned nact);
    int unsigned lg;
    lg = 0;
    for (int i = 0; i < 8; i++) begin
      if ((32'd1 << lg) < nact) lg = lg + 1;
    end
    return lg;
  endfunction

  // entries per slice
  function automatic int unsigned slice_entries(input int unsigned depth,
                                                input int unsigned nact);
    return depth >> slice_log2(nact);
  endfunction

  // first physical entry of a slice
  function automatic int unsigned slot_base(input int unsigned slot,
                                            input int unsigned entries);
    return slot * entries;
  endfunction

endpackage

// File: rtl/rsp_partition.sv
module rsp_partition #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 16,
  parameter int TIDW  = 2,
  parameter int FILLW = 5,
  parameter int CNTW  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTHR-1:0]            act_mask,
  output logic                       flush,
  output logic [FILLW-1:0]           slice_sz,
  output logic [NTHR-1:0][TIDW-1:0]  rank
);
  import rsp_pkg::*;

  logic [CNTW-1:0] nact;
  logic [CNTW-1:0] cnt_q;

  always_comb begin
    nact = '0;
    for (int t = 0; t < NTHR; t++) nact = nact + CNTW'(act_mask[t]);
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      rank[t] = '0;
      for (int u = 0; u < t; u++) rank[t] = rank[t] + TIDW'(act_mask[u]);
    end
  end

  assign slice_sz = FILLW'(slice_entries(DEPTH, 32'(nact)));
  assign flush    = (nact != cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nact;
  end

  // R8: a flush lasts one cycle unless the mask moves again
  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flush || !$stable(act_mask)));

  // R2: capacity always one of the legal sizes
  assert_slice_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(slice_sz) == DEPTH) || (32'(slice_sz) == DEPTH / 2) || (32'(slice_sz) == DEPTH / 4));

  generate
    for (genvar g = 0; g < NTHR; g++) begin : g_rank_chk
      // R6: an active thread's slice lies inside the pool
      assert_slice_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_mask[g] |-> (32'(rank[g]) * 32'(slice_sz) < DEPTH));
    end
  endgenerate

endmodule

// File: rtl/rsp_slot.sv
module rsp_slot #(
  parameter int IDXW  = 4,
  parameter int FILLW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [FILLW-1:0] size,
  input  logic             pop_req,
  input  logic             push_req,
  output logic [IDXW-1:0]  top_q,
  output logic [FILLW-1:0] fill_q,
  output logic             pop_ok,
  output logic [IDXW-1:0]  wr_local
);
  logic [IDXW-1:0]  wrap;
  logic [IDXW-1:0]  top_mid, top_nxt;
  logic [FILLW-1:0] fill_mid, fill_nxt;

  assign wrap   = IDXW'(size - FILLW'(1));
  assign pop_ok = pop_req && (fill_q != '0);

  // pop first, then push
  always_comb begin
    top_mid  = pop_ok ? ((top_q - IDXW'(1)) & wrap) : top_q;
    fill_mid = pop_ok ? (fill_q - FILLW'(1)) : fill_q;
    top_nxt  = push_req ? ((top_mid + IDXW'(1)) & wrap) : top_mid;
    if (push_req && (fill_mid != size)) fill_nxt = fill_mid + FILLW'(1);
    else                                 fill_nxt = fill_mid;
  end

  assign wr_local = top_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      top_q  <= '0;
      fill_q <= '0;
    end else begin
      top_q  <= top_nxt;
      fill_q <= fill_nxt;
    end
  end

  // R4: occupancy never exceeds the slice
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (fill_q <= size));

  // R8: flush empties the slice
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_q == '0));

  // R4: a push into a full slice leaves it full
  assert_full_stays_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_req && !pop_req && fill_q == size) |=> (fill_q == $past(size)));

  // R9: pop+push on a non-empty slice keeps occupancy
  assert_pop_push_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_req && pop_req && fill_q != '0) |=> (fill_q == $past(fill_q)));

  // R5: pop on empty leaves it empty
  assert_empty_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && pop_req && !push_req && fill_q == '0) |=> (fill_q == '0));

endmodule

// File: rtl/rsp_store.sv
module rsp_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [AW-1:0]   wdata,
  input  logic [IDXW-1:0] raddr,
  output logic [AW-1:0]   rdata
);
  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ret_stack_part.sv
module ret_stack_part #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTHR-1:0]         act_mask,
  input  logic                    push_vld,
  input  logic [$clog2(NTHR)-1:0] push_tid,
  input  logic [AW-1:0]           push_addr,
  input  logic                    pop_vld,
  input  logic [$clog2(NTHR)-1:0] pop_tid,
  output logic                    pred_vld,
  output logic [AW-1:0]           pred_addr
);
  import rsp_pkg::*;

  localparam int TIDW  = $clog2(NTHR);
  localparam int IDXW  = $clog2(DEPTH);
  localparam int FILLW = IDXW + 1;
  localparam int CNTW  = $clog2(NTHR + 1);
  localparam int NSLOT = NTHR;

  logic                      flush;
  logic [FILLW-1:0]          slice_sz;
  logic [NTHR-1:0][TIDW-1:0] rank;

  rsp_partition #(.NTHR(NTHR), .DEPTH(DEPTH), .TIDW(TIDW), .FILLW(FILLW), .CNTW(CNTW)) u_part (
    .clk(clk), .rst_n(rst_n), .act_mask(act_mask),
    .flush(flush), .slice_sz(slice_sz), .rank(rank)
  );

  // accepted requests and their target slices
  logic            pop_go, push_go;
  logic [TIDW-1:0] pop_slot, push_slot;

  assign pop_go    = pop_vld  && act_mask[pop_tid]  && !flush;
  assign push_go   = push_vld && act_mask[push_tid] && !flush;
  assign pop_slot  = rank[pop_tid];
  assign push_slot = rank[push_tid];

  logic [NSLOT-1:0]            pop_req_v, push_req_v, slot_pop_ok;
  logic [NSLOT-1:0][IDXW-1:0]  slot_top, slot_wr;
  logic [NSLOT-1:0][FILLW-1:0] slot_fill;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign pop_req_v[s]  = pop_go  && (32'(pop_slot)  == s);
      assign push_req_v[s] = push_go && (32'(push_slot) == s);

      rsp_slot #(.IDXW(IDXW), .FILLW(FILLW)) u_slot (
        .clk(clk), .rst_n(rst_n), .flush(flush), .size(slice_sz),
        .pop_req(pop_req_v[s]), .push_req(push_req_v[s]),
        .top_q(slot_top[s]), .fill_q(slot_fill[s]),
        .pop_ok(slot_pop_ok[s]), .wr_local(slot_wr[s])
      );
    end
  endgenerate

  logic            pop_hit;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic [AW-1:0]   rd_data;

  assign pop_hit = |slot_pop_ok;
  assign rd_idx  = IDXW'(slot_base(32'(pop_slot),  32'(slice_sz)) + 32'(slot_top[pop_slot]));
  assign wr_idx  = IDXW'(slot_base(32'(push_slot), 32'(slice_sz)) + 32'(slot_wr[push_slot]));

  rsp_store #(.DEPTH(DEPTH), .AW(AW), .IDXW(IDXW)) u_store (
    .clk(clk), .we(push_go), .waddr(wr_idx), .wdata(push_addr),
    .raddr(rd_idx), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_vld  <= 1'b0;
      pred_addr <= '0;
    end else begin
      pred_vld  <= pop_hit;
      pred_addr <= pop_hit ? rd_data : '0;
    end
  end

  // R6: at most one slice serves a pop or a push
  assert_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_req_v) && $onehot0(push_req_v));

  // R3: a valid prediction only follows a pop request
  assert_pred_from_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> $past(pop_vld));

  // R5: pop on an empty slice gives an invalid, zero prediction
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_go && (slot_fill[pop_slot] == '0)) |=> (!pred_vld && pred_addr == '0));

  // R10: pops of inactive threads predict nothing
  assert_inactive_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_vld && !act_mask[pop_tid]) |=> !pred_vld);

  // R8: requests during a flush are discarded
  assert_flush_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_vld);

endmodule

// File: tb/sim_ret_stack_part.sv
module sim_ret_stack_part;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR  = 4;
  localparam int DEPTH = 16;
  localparam int AW    = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NTHR-1:0] act_mask = '0;
  logic            push_vld = 1'b0;
  logic [1:0]      push_tid = '0;
  logic [AW-1:0]   push_addr = '0;
  logic            pop_vld = 1'b0;
  logic [1:0]      pop_tid = '0;
  logic            pred_vld;
  logic [AW-1:0]   pred_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ret_stack_part #(.NTHR(NTHR), .DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .act_mask(act_mask),
    .push_vld(push_vld), .push_tid(push_tid), .push_addr(push_addr),
    .pop_vld(pop_vld), .pop_tid(pop_tid),
    .pred_vld(pred_vld), .pred_addr(pred_addr)
  );

  int checks = 0;
  int fails  = 0;

  // per-thread model: index 0 oldest, mcnt-1 newest
  logic [AW-1:0] mdl [NTHR][DEPTH];
  int            mcnt [NTHR];
  int            cap = DEPTH;
  int            last_cnt = 0;

  function automatic int pop_count(input logic [NTHR-1:0] m);
    int n = 0;
    for (int i = 0; i < NTHR; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic int cap_for(input int n);
    if (n <= 1) return DEPTH;
    if (n == 2) return DEPTH / 2;
    return DEPTH / 4;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mpop(input int t, output bit v, output logic [AW-1:0] a);
    v = 1'b0; a = '0;
    if (act_mask[t] && mcnt[t] > 0) begin
      v = 1'b1;
      a = mdl[t][mcnt[t] - 1];
      mcnt[t]--;
    end
  endtask

  task automatic mpush(input int t, input logic [AW-1:0] a);
    if (!act_mask[t]) return;
    if (mcnt[t] == cap) begin
      for (int i = 0; i < cap - 1; i++) mdl[t][i] = mdl[t][i + 1];
      mdl[t][cap - 1] = a;
    end else begin
      mdl[t][mcnt[t]] = a;
      mcnt[t]++;
    end
  endtask

  // one cycle: inputs applied at a falling edge, result read at the next
  task automatic step(input bit dpush, input int ptid, input logic [AW-1:0] paddr,
                      input bit dpop, input int otid, input string req);
    bit            ev;
    logic [AW-1:0] ea;
    int            n;
    ev = 1'b0; ea = '0;
    push_vld = dpush; push_tid = 2'(ptid); push_addr = paddr;
    pop_vld  = dpop;  pop_tid  = 2'(otid);
    n = pop_count(act_mask);
    if (n != last_cnt) begin
      for (int t = 0; t < NTHR; t++) mcnt[t] = 0;
      cap = cap_for(n);
      last_cnt = n;
    end else begin
      if (dpop)  mpop(otid, ev, ea);
      if (dpush) mpush(ptid, paddr);
    end
    @(negedge clk);
    push_vld = 1'b0; pop_vld = 1'b0;
    check(pred_vld == ev && pred_addr == ea, req, {pred_vld, pred_addr}, {ev, ea});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < NTHR; t++) mcnt[t] = 0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(pred_vld == 1'b0 && pred_addr == '0, "R1 reset", {pred_vld, pred_addr}, '0);
    end
    rst_n = 1'b1;
    act_mask = 4'b0001;
    step(0, 0, '0, 0, 0, "R8 flush");
    step(0, 0, '0, 1, 0, "R1 empty after reset");
    step(0, 0, '0, 1, 0, "R5 empty pop");

    // R3: latency and one-cycle pulse
    step(1, 0, 32'hCAFE_0001, 0, 0, "R3 push");
    step(0, 0, '0, 1, 0, "R3 pop result");
    step(0, 0, '0, 0, 0, "R3 idle no pred");

    // sweep of all masks: R2 R4 R6 R7 R10
    for (int m = 1; m < 16; m++) begin
      string tag;
      act_mask = '0;
      step(0, 0, '0, 0, 0, "R8 flush to zero");
      act_mask = 4'(m);
      step(0, 0, '0, 0, 0, "R8 flush to mask");
      tag = (pop_count(4'(m)) == 3) ? "R7 R2 R4 R6 R10" : "R2 R4 R6 R10";
      for (int t = 0; t < NTHR; t++)
        for (int i = 0; i < cap + 2; i++)
          step(1, t, {8'(m), 8'(t), 16'(i)}, 0, 0, tag);
      for (int t = 0; t < NTHR; t++)
        for (int i = 0; i < cap + 2; i++)
          step(0, 0, '0, 1, t, tag);
    end

    // R8: count change mid-run discards contents and that cycle's push
    act_mask = 4'b0011;
    step(0, 0, '0, 0, 0, "R8 flush");
    step(1, 0, 32'h0000_00A0, 0, 0, "R8 push");
    step(1, 1, 32'h0000_00B1, 0, 0, "R8 push");
    act_mask = 4'b0111;
    step(1, 0, 32'h0000_00C0, 1, 1, "R8 discarded");
    step(0, 0, '0, 1, 0, "R8 emptied t0");
    step(0, 0, '0, 1, 1, "R8 emptied t1");

    // R9: pop then push in one cycle
    act_mask = 4'b1111;
    step(0, 0, '0, 0, 0, "R8 flush");
    step(1, 0, 32'h0000_0A00, 0, 0, "R9 push");
    step(1, 0, 32'h0000_0B00, 0, 0, "R9 push");
    step(1, 0, 32'h0000_0C00, 1, 0, "R9 pop+push");
    step(0, 0, '0, 1, 0, "R9 new top");
    step(0, 0, '0, 1, 0, "R9 older");
    step(0, 0, '0, 1, 0, "R9 drained");
    step(1, 1, 32'h0000_0D11, 1, 1, "R9 pop+push empty");
    step(0, 0, '0, 1, 1, "R9 kept push");
    step(1, 2, 32'h0000_0E22, 1, 3, "R6 other thread pop");
    step(0, 0, '0, 1, 2, "R6 own pop");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule